// File: doc/BRIEF.md
# I2C Serial Clock Divider

This block produces the serial clock level for an I2C master from a fast system clock. A programmable prescaler reduces the system clock to a slower module tick. Two programmable counts then set how many ticks SCL spends low and high. Each phase is lengthened by a fixed offset, and that offset depends on the prescaler setting: the actual phase lengths are the programmed counts plus 7, 6 or 5 ticks. The prescaler is meant to be set so that the module tick rate falls between 7 MHz and 12 MHz.

Software loads the prescaler, low count and high count through a simple write port while a run bit is clear. It then sets the run bit to start the clock. While run is clear, SCL is released high and every counter is held at zero. Writes made while the clock runs are held in the programmed registers. They are copied into working copies only at a phase boundary, so a phase in progress is never shortened or stretched. Besides the SCL level, the block issues a one-cycle strobe on each rising and each falling SCL edge for a downstream bit engine. Everything runs on the single system clock, with clock enables and no derived clocks.

Top module: `sclk_gen`

## Requirements
- R1: After reset, and whenever the run bit is clear, SCL is high and neither strobe is asserted, even with divider values programmed.
- R2: The module tick occurs once every PSC+1 system clock cycles, where PSC is the prescaler register (write address 0). Every phase length in ticks is therefore multiplied by PSC+1 in system cycles.
- R3: The high phase of SCL lasts CLKH+d ticks, where CLKH is the high count register (write address 2).
- R4: The low phase of SCL lasts CLKL+d ticks, where CLKL is the low count register (write address 1).
- R5: The offset d is 7 when PSC is 0, 6 when PSC is 1, and 5 when PSC is 2 or more.
- R6: Writing 1 to bit 0 of the control register (write address 3) starts the clock from cleared counters with a high phase. The first falling edge is captured exactly (CLKH+d)*(PSC+1) cycles after the clock edge that captured the write.
- R7: Writes to PSC, CLKL or CLKH while running leave the current phase unchanged. They take effect from the next phase boundary, including the change of d and of the tick rate.
- R8: The rise strobe is high for exactly the one cycle in which SCL first reads high after a low phase. The fall strobe is high for exactly the one cycle in which SCL first reads low. The two strobes are never high together.
- R9: Clearing the run bit in mid-phase forces SCL high on the second clock edge after the write, with no rise strobe. Setting run again restarts the timing from zero as in R6.
- R10: A divider write captured on the same clock edge as a phase boundary is not used for the phase that starts at that edge. It applies from the following boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register select: 0 prescaler, 1 low count, 2 high count, 3 control |
| wr_data | input | DW | Write data; for the control register only bit 0 (run) is used |
| scl_o | output | 1 | Serial clock level |
| scl_rise_o | output | 1 | One-cycle strobe in the first cycle SCL is high |
| scl_fall_o | output | 1 | One-cycle strobe in the first cycle SCL is low |

## Verification
The two functions that can land in one cycle are a register write and a phase boundary that reloads the working copies. The bench provokes this by timing a high-count write so that it is captured on the very edge where SCL rises. It then checks the next two falling edges. The first must still use the old high count, and only the one after uses the new value. A scoreboard predicts every strobe's cycle from the requirement formulas, so a copy that takes the new value one phase early misses by a known number of cycles.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

   // Register select codes seen on the write port
   typedef enum logic [1:0] {
      SEL_PRESCALE = 2'd0,
      SEL_LOW      = 2'd1,
      SEL_HIGH     = 2'd2,
      SEL_CTRL     = 2'd3
   } sclk_sel_e;

   // Number of divider registers that are shadowed
   localparam int unsigned NUM_DIV  = 3;
   localparam int unsigned IDX_PSC  = 0;
   localparam int unsigned IDX_LOW  = 1;
   localparam int unsigned IDX_HIGH = 2;

   // Control register bit that lets the divider run
   localparam int unsigned CTRL_RUN_BIT = 0;

   // Phase stretch per prescaler setting
   localparam int unsigned OFS_W = 3;
   localparam logic [OFS_W-1:0] OFS_UNDIVIDED = 3'd7;
   localparam logic [OFS_W-1:0] OFS_HALVED    = 3'd6;
   localparam logic [OFS_W-1:0] OFS_SLOWER    = 3'd5;

   function automatic logic [OFS_W-1:0] phase_offset(input logic psc_is_zero,
                                                     input logic psc_is_one);
      logic [OFS_W-1:0] r;
      if (psc_is_zero)
         r = OFS_UNDIVIDED;
      else if (psc_is_one)
         r = OFS_HALVED;
      else
         r = OFS_SLOWER;
      return r;
   endfunction

endpackage

// File: rtl/sclk_regs.sv
module sclk_regs
   import sclk_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          load,
   output logic          run,
   output logic [DW-1:0] psc_sh,
   output logic [DW-1:0] lo_sh,
   output logic [DW-1:0] hi_sh
);

   localparam int unsigned SEL_SPAN = 1 << $bits(wr_addr);

   generate
      if (NUM_DIV + 1 > SEL_SPAN) begin : g_bad_map
         $error("sclk_regs: register select too narrow for the register set");
      end
   endgenerate

   sclk_sel_e             sel;
   logic                  run_q;
   logic [NUM_DIV-1:0][DW-1:0] prog_w;
   logic [NUM_DIV-1:0][DW-1:0] work_w;

   assign sel = sclk_sel_e'(wr_addr);

   // Control register: run enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= 1'b0;
      else if (wr_en && sel == SEL_CTRL)
         run_q <= wr_data[CTRL_RUN_BIT];
   end

   // One programmed register and one working copy per divider field.
   // Working copies follow the programmed value while stopped and are
   // refreshed only at a phase boundary while running.
   generate
      for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
         logic [DW-1:0] prog_q;
         logic [DW-1:0] work_q;
         logic          hit;

         assign hit = wr_en && (wr_addr == 2'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               prog_q <= '0;
            else if (hit)
               prog_q <= wr_data;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               work_q <= '0;
            else if (!run_q || load)
               work_q <= prog_q;
         end

         assign prog_w[i] = prog_q;
         assign work_w[i] = work_q;
      end
   endgenerate

   assign run    = run_q;
   assign psc_sh = work_w[IDX_PSC];
   assign lo_sh  = work_w[IDX_LOW];
   assign hi_sh  = work_w[IDX_HIGH];

endmodule

// File: rtl/sclk_prescale.sv
module sclk_prescale #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [DW-1:0] div,
   output logic          tick
);

   logic [DW-1:0] pc_q;

   // Tick on the last count of each module period
   assign tick = run && (pc_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc_q <= '0;
      else if (!run || tick)
         pc_q <= '0;
      else
         pc_q <= pc_q + DW'(1);
   end

endmodule

// File: rtl/sclk_phase.sv
module sclk_phase
   import sclk_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic [DW-1:0] psc_sh,
   input  logic [DW-1:0] lo_sh,
   input  logic [DW-1:0] hi_sh,
   output logic          scl,
   output logic          rise_stb,
   output logic          fall_stb,
   output logic          boundary
);

   // One extra bit holds count plus offset without wrap
   localparam int unsigned CW = DW + 1;

   logic [CW-1:0]    cnt_q;
   logic [CW-1:0]    cnt_inc;
   logic [CW-1:0]    target;
   logic [DW-1:0]    cur_count;
   logic [OFS_W-1:0] ofs;

   always_comb begin
      ofs       = phase_offset(psc_sh == '0, psc_sh == DW'(1));
      cur_count = scl ? hi_sh : lo_sh;
      target    = {1'b0, cur_count} + CW'(ofs);
      cnt_inc   = cnt_q + CW'(1);
      boundary  = tick && (cnt_inc >= target);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         scl      <= 1'b1;
         rise_stb <= 1'b0;
         fall_stb <= 1'b0;
      end else if (!run) begin
         cnt_q    <= '0;
         scl      <= 1'b1;
         rise_stb <= 1'b0;
         fall_stb <= 1'b0;
      end else begin
         rise_stb <= 1'b0;
         fall_stb <= 1'b0;
         if (boundary) begin
            cnt_q    <= '0;
            scl      <= ~scl;
            rise_stb <= ~scl;
            fall_stb <= scl;
         end else if (tick) begin
            cnt_q <= cnt_inc;
         end
      end
   end

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
   import sclk_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          scl_o,
   output logic          scl_rise_o,
   output logic          scl_fall_o
);

   generate
      if (DW < 4 || DW > 30) begin : g_bad_width
         $error("sclk_gen: DW must lie between 4 and 30");
      end
   endgenerate

   logic          run;
   logic          tick;
   logic          boundary;
   logic [DW-1:0] psc_sh;
   logic [DW-1:0] lo_sh;
   logic [DW-1:0] hi_sh;

   sclk_regs #(.DW(DW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .load    (boundary),
      .run     (run),
      .psc_sh  (psc_sh),
      .lo_sh   (lo_sh),
      .hi_sh   (hi_sh)
   );

   sclk_prescale #(.DW(DW)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .div   (psc_sh),
      .tick  (tick)
   );

   sclk_phase #(.DW(DW)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tick     (tick),
      .psc_sh   (psc_sh),
      .lo_sh    (lo_sh),
      .hi_sh    (hi_sh),
      .scl      (scl_o),
      .rise_stb (scl_rise_o),
      .fall_stb (scl_fall_o),
      .boundary (boundary)
   );

endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk #(
   parameter int unsigned DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run,
   input logic          tick,
   input logic          boundary,
   input logic          scl,
   input logic          rise,
   input logic          fall,
   input logic [DW-1:0] psc_sh,
   input logic [DW-1:0] lo_sh,
   input logic [DW-1:0] hi_sh
);

   // Independent count of cycles since the last tick
   logic [DW-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap_q <= '0;
      else if (!run || tick)
         gap_q <= '0;
      else
         gap_q <= gap_q + DW'(1);
   end

   p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (scl && !rise && !fall));

   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick) |-> (gap_q == psc_sh));

   p_tick_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |-> (gap_q < psc_sh));

   p_toggle_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && (scl != $past(scl))) |-> $past(tick));

   p_start_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> scl);

   p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(boundary)) |->
         ($stable(psc_sh) && $stable(lo_sh) && $stable(hi_sh)));

   p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise && fall));

   p_rise_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rise |-> (scl && !$past(scl)));

   p_fall_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fall |-> (!scl && $past(scl)));

   p_rise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

bind sclk_gen sclk_gen_chk #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run),
   .tick     (tick),
   .boundary (boundary),
   .scl      (scl_o),
   .rise     (scl_rise_o),
   .fall     (scl_fall_o),
   .psc_sh   (psc_sh),
   .lo_sh    (lo_sh),
   .hi_sh    (hi_sh)
);

// File: tb/sim_sclk_gen.sv
`timescale 1ns/1ps
module sim_sclk_gen;

   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = 2'd0;
   logic [DW-1:0] wr_data = '0;
   logic          scl;
   logic          rise;
   logic          fall;

   always #5 clk = ~clk;

   sclk_gen #(.DW(DW)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .scl_o      (scl),
      .scl_rise_o (rise),
      .scl_fall_o (fall)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      bit    is_rise;
      int    at;
      string req;
   } ev_t;

   ev_t exp_q[$];
   ev_t mon_e;
   int  n_vec = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   // Monitor: pops the scoreboard on every strobe
   always @(negedge clk) begin
      if (rst_n && (rise || fall)) begin
         if (rise && fall)
            chk(1'b0, "R8 both strobes together", 1, 0);
         if (exp_q.size() == 0) begin
            chk(1'b0, "unexpected strobe R1 R9", cyc, -1);
         end else begin
            mon_e = exp_q.pop_front();
            chk(rise == mon_e.is_rise, {mon_e.req, " strobe kind R8"}, int'(rise), int'(mon_e.is_rise));
            chk(cyc == mon_e.at, {mon_e.req, " edge cycle"}, cyc, mon_e.at);
            chk(scl == mon_e.is_rise, {mon_e.req, " level with strobe R8"}, int'(scl), int'(mon_e.is_rise));
         end
      end
   end

   function automatic int d_of(input int p);
      if (p == 0) return 7;
      if (p == 1) return 6;
      return 5;
   endfunction

   function automatic int dur(input int cnt, input int p);
      return (cnt + d_of(p)) * (p + 1);
   endfunction

   // Called at a negedge; the write is captured at the next posedge
   task automatic reg_write(input logic [1:0] a, input int v);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = v[DW-1:0];
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic push(input bit r, input int t, input string q);
      ev_t e;
      e.is_rise = r;
      e.at      = t;
      e.req     = q;
      exp_q.push_back(e);
   endtask

   task automatic stop_check(input string q);
      reg_write(2'd3, 0);
      @(negedge clk);
      chk(scl == 1'b1, {q, " R9 level after stop"}, int'(scl), 1);
      chk(exp_q.size() == 0, {q, " R3 R4 pending strobes"}, exp_q.size(), 0);
   endtask

   task automatic run_basic(input int p, input int l, input int h, input int nper, input string q);
      int t;
      reg_write(2'd0, p);
      reg_write(2'd1, l);
      reg_write(2'd2, h);
      reg_write(2'd3, 1);
      t = cyc;
      chk(scl == 1'b1, {q, " R6 starts high"}, int'(scl), 1);
      for (int k = 0; k < nper; k++) begin
         t += dur(h, p);
         push(1'b0, t, {q, " fall"});
         t += dur(l, p);
         push(1'b1, t, {q, " rise"});
      end
      wait_until(t);
      stop_check(q);
   endtask

   initial begin : main
      int t, t1, t2, t3, t4, a, b, c, d, e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(scl == 1'b1, "R1 reset level", int'(scl), 1);
      chk(!rise && !fall, "R1 no strobes after reset", int'(rise | fall), 0);

      // Programmed but not running
      reg_write(2'd0, 0);
      reg_write(2'd1, 3);
      reg_write(2'd2, 2);
      repeat (30) @(negedge clk);
      chk(scl == 1'b1, "R1 idle while stopped", int'(scl), 1);

      run_basic(0, 3, 2, 2, "R3 R4 R5 R6 d7");
      run_basic(1, 0, 4, 2, "R2 R5 d6");
      run_basic(2, 2, 1, 2, "R2 R5 d5");
      run_basic(5, 1, 0, 1, "R2 R4 wide prescale");

      // R7: changes while running wait for the boundary
      reg_write(2'd0, 0);
      reg_write(2'd1, 1);
      reg_write(2'd2, 1);
      reg_write(2'd3, 1);
      t  = cyc;
      t1 = t + dur(1, 0);
      push(1'b0, t1, "R7 first fall");
      wait_until(t1);
      reg_write(2'd0, 1);
      reg_write(2'd1, 2);
      reg_write(2'd2, 3);
      t2 = t1 + dur(1, 0);
      push(1'b1, t2, "R7 current low kept");
      t3 = t2 + dur(3, 1);
      push(1'b0, t3, "R7 new high and prescale");
      t4 = t3 + dur(2, 1);
      push(1'b1, t4, "R7 new low");
      wait_until(t4);
      stop_check("R7");

      // R10: write captured on the boundary edge
      reg_write(2'd0, 0);
      reg_write(2'd1, 2);
      reg_write(2'd2, 3);
      reg_write(2'd3, 1);
      t = cyc;
      a = t + dur(3, 0);
      push(1'b0, a, "R10 setup fall");
      b = a + dur(2, 0);
      push(1'b1, b, "R10 setup rise");
      wait_until(b - 1);
      reg_write(2'd2, 6);
      c = b + dur(3, 0);
      push(1'b0, c, "R10 old high on collision");
      d = c + dur(2, 0);
      push(1'b1, d, "R10 low");
      e = d + dur(6, 0);
      push(1'b0, e, "R10 new high next phase");
      wait_until(e);
      stop_check("R10 stop in low");

      // R9: stop in mid-phase and restart fresh
      reg_write(2'd1, 4);
      reg_write(2'd2, 4);
      reg_write(2'd3, 1);
      t  = cyc;
      t1 = t + dur(4, 0);
      push(1'b0, t1, "R9 before stop");
      wait_until(t1 + 3);
      stop_check("R9 mid-low stop");
      repeat (30) @(negedge clk);
      chk(scl == 1'b1, "R9 stays high while stopped", int'(scl), 1);
      reg_write(2'd3, 1);
      t = cyc;
      push(1'b0, t + dur(4, 0), "R9 restart fall");
      push(1'b1, t + dur(4, 0) + dur(4, 0), "R9 restart rise");
      wait_until(t + 2 * dur(4, 0));
      stop_check("R9 restart");

      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R3 R4 scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : watchdog
      #2000000;
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog R1: actual %0d expected %0d", cyc, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule